// File: doc/BRIEF.md
# Delay-Line Tap Steering Controller

This block drives the tap select of a 256-position delay line so that a feedback clock edge lands on the reference clock edge. An external phase detector reports one decision per reference cycle: a valid strobe and a direction bit that says whether the feedback edge came early or late. The controller adds a tap when the edge is early and removes a tap when it is late. It raises a lock flag once the decisions show that the loop is dithering around alignment. Logic fed by the delayed clock must treat that clock as invalid until the lock flag is high.

After lock, the controller keeps tracking slow supply and temperature drift. It accepts at most one correction per refresh interval, which is a cycle count set by a parameter. If a correction would push the tap past either end of the line, the controller gives up. It drops lock, raises the overflow flag and freezes until a synchronous reset.

The controller is a three-state machine:
- ACQUIRE applies every decision and qualifies lock.
- TRACK applies one decision per refresh window.
- FAULT is terminal.

The transitions are:
- LOCK_FOUND: ACQUIRE to TRACK.
- LIMIT_HIT: ACQUIRE or TRACK to FAULT.
- RESET: any state to ACQUIRE.

Top module: `dll_tap_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the block leaves that edge with `tap_sel` = 128 (the midpoint, 2^(TAP_BITS-1)), `locked` = 0 and `overflow` = 0.
- R2: In ACQUIRE, each cycle with `dec_valid` = 1 changes `tap_sel` at that edge: it goes up by one when `dec_early` = 1 and down by one when `dec_early` = 0.
- R3: A cycle with `dec_valid` = 0 never changes `tap_sel`, in any state.
- R4: `locked` rises at the edge that takes the LOCK_RUN-th consecutive valid decision, where each decision in the run has the opposite `dec_early` value to the one before it (default LOCK_RUN = 8). A decision in the same direction as the previous one starts a new run with length one.
- R5: In TRACK, `locked` stays high and the tap moves at most once per REFRESH_CYCLES cycles. A refresh opportunity is raised when REFRESH_CYCLES cycles have passed since entering TRACK, and again every REFRESH_CYCLES cycles after that. Each opportunity is used by the next valid decision. If decisions arrive every cycle, the first step comes REFRESH_CYCLES+1 edges after the lock edge, and later steps come every REFRESH_CYCLES edges.
- R6: An applied decision that would move the tap past the end of the line (early at 255, or late at 0) leaves `tap_sel` unchanged, sets `overflow` = 1 and clears `locked`. Reaching 255 or 0 by a legal step does not set `overflow`.
- R7: Once `overflow` is set, further decisions have no effect. `tap_sel`, `overflow` = 1 and `locked` = 0 hold until reset.
- R8: `locked` and `overflow` are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock; one phase decision at most per cycle |
| rst | input | 1 | Synchronous active-high reset |
| dec_valid | input | 1 | A phase decision is present this cycle |
| dec_early | input | 1 | 1 = feedback edge early (add delay), 0 = late (remove delay) |
| tap_sel | output | TAP_BITS (8) | Delay-line tap select |
| locked | output | 1 | Feedback aligned; the delayed clock is usable |
| overflow | output | 1 | A tap limit was hit; lock lost until reset |

## Verification
The bench builds the controller with the full 8-bit tap range and a run length of 8. It shortens the refresh interval to 8 cycles. The full tap range makes both complete sweeps reachable, from the midpoint up to 255 and down to 0, with every tap value checked along the way. Both limit violations also become reachable. The short interval makes several refresh windows observable cycle by cycle. The run length of 8 allows a sweep over every point at which a dithering run can be broken, from one to seven alternations, before a full run locks.

// File: rtl/dll_tap_pkg.sv
package dll_tap_pkg;

    typedef enum logic [1:0] {
        ST_ACQUIRE = 2'd0,
        ST_TRACK   = 2'd1,
        ST_FAULT   = 2'd2
    } dll_state_e;

endpackage

// File: rtl/dll_tap_counter.sv
// Up/down tap register with end-of-line detection.
module dll_tap_counter #(
    parameter int TAP_BITS = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                step_en,
    input  logic                step_up,
    output logic [TAP_BITS-1:0] tap,
    output logic                limit_hit
);
    localparam logic [TAP_BITS-1:0] MID_TAP = TAP_BITS'(1) << (TAP_BITS - 1);
    localparam logic [TAP_BITS-1:0] TOP_TAP = '1;
    localparam logic [TAP_BITS-1:0] BOT_TAP = '0;

    // A requested step that would leave the line is refused and reported.
    always_comb begin
        limit_hit = step_en && ((step_up && tap == TOP_TAP) ||
                                (!step_up && tap == BOT_TAP));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tap <= MID_TAP;
        end else if (step_en && !limit_hit) begin
            if (step_up) begin
                tap <= tap + TAP_BITS'(1);
            end else begin
                tap <= tap - TAP_BITS'(1);
            end
        end
    end

endmodule

// File: rtl/dll_lock_qual.sv
// Counts consecutive alternating phase decisions.
module dll_lock_qual #(
    parameter int LOCK_RUN = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic dec_valid,
    input  logic dec_early,
    output logic run_done
);
    localparam int RW = $clog2(LOCK_RUN + 1);
    localparam logic [RW-1:0] RUN_FULL = RW'(LOCK_RUN);

    logic          prev_dir;
    logic          have_prev;
    logic [RW-1:0] run_q;
    logic [RW-1:0] run_nxt;

    always_comb begin
        run_nxt = run_q;
        if (dec_valid) begin
            if (have_prev && (dec_early != prev_dir)) begin
                run_nxt = (run_q == RUN_FULL) ? run_q : run_q + RW'(1);
            end else begin
                run_nxt = RW'(1);
            end
        end
        run_done = dec_valid && (run_nxt == RUN_FULL);
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            prev_dir  <= 1'b0;
            have_prev <= 1'b0;
            run_q     <= '0;
        end else if (dec_valid) begin
            prev_dir  <= dec_early;
            have_prev <= 1'b1;
            run_q     <= run_nxt;
        end
    end

endmodule

// File: rtl/dll_refresh_timer.sv
// Raises a refresh opportunity once per interval while running.
module dll_refresh_timer #(
    parameter int REFRESH_CYCLES = 1024
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic consume,
    output logic due
);
    localparam int CW = (REFRESH_CYCLES > 2) ? $clog2(REFRESH_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(REFRESH_CYCLES - 1);

    logic [CW-1:0] cnt;
    logic          wrap;

    always_comb begin
        wrap = (cnt == LAST);
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
            due <= 1'b0;
        end else begin
            cnt <= wrap ? '0 : cnt + CW'(1);
            due <= wrap || (due && !consume);
        end
    end

endmodule

// File: rtl/dll_tap_ctrl.sv
// Delay-line tap steering controller: top-level state machine.
module dll_tap_ctrl #(
    parameter int TAP_BITS       = 8,
    parameter int LOCK_RUN       = 8,
    parameter int REFRESH_CYCLES = 1024
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                dec_valid,
    input  logic                dec_early,
    output logic [TAP_BITS-1:0] tap_sel,
    output logic                locked,
    output logic                overflow
);
    import dll_tap_pkg::*;

    dll_state_e state_q;
    dll_state_e state_d;

    logic step_en;
    logic limit_hit;
    logic run_done;
    logic refresh_due;

    // Which decisions reach the tap counter in each state.
    always_comb begin
        unique case (state_q)
            ST_ACQUIRE: step_en = dec_valid;
            ST_TRACK:   step_en = dec_valid && refresh_due;
            default:    step_en = 1'b0;
        endcase
    end

    dll_tap_counter #(
        .TAP_BITS (TAP_BITS)
    ) tap_cnt_i (
        .clk       (clk),
        .rst       (rst),
        .step_en   (step_en),
        .step_up   (dec_early),
        .tap       (tap_sel),
        .limit_hit (limit_hit)
    );

    dll_lock_qual #(
        .LOCK_RUN (LOCK_RUN)
    ) lock_q_i (
        .clk       (clk),
        .rst       (rst),
        .clear     (state_q != ST_ACQUIRE),
        .dec_valid (dec_valid),
        .dec_early (dec_early),
        .run_done  (run_done)
    );

    dll_refresh_timer #(
        .REFRESH_CYCLES (REFRESH_CYCLES)
    ) refresh_i (
        .clk     (clk),
        .rst     (rst),
        .run     (state_q == ST_TRACK),
        .consume (step_en),
        .due     (refresh_due)
    );

    // Next-state logic: LOCK_FOUND, LIMIT_HIT.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ACQUIRE: begin
                if (limit_hit) begin
                    state_d = ST_FAULT;
                end else if (run_done) begin
                    state_d = ST_TRACK;
                end
            end
            ST_TRACK: begin
                if (limit_hit) begin
                    state_d = ST_FAULT;
                end
            end
            ST_FAULT: state_d = ST_FAULT;
            default:  state_d = ST_FAULT;
        endcase
    end

    // State register; RESET returns to ACQUIRE.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_ACQUIRE;
        end else begin
            state_q <= state_d;
        end
    end

    // Output decode.
    always_comb begin
        locked   = 1'b0;
        overflow = 1'b0;
        unique case (state_q)
            ST_ACQUIRE: ;
            ST_TRACK:   locked = 1'b1;
            ST_FAULT:   overflow = 1'b1;
            default:    overflow = 1'b1;
        endcase
    end

endmodule

// File: rtl/dll_tap_ctrl_chk.sv
// Property checker attached to the controller.
module dll_tap_ctrl_chk #(
    parameter int TAP_BITS = 8
) (
    input logic                clk,
    input logic                rst,
    input logic                dec_valid,
    input logic [TAP_BITS-1:0] tap_sel,
    input logic                locked,
    input logic                overflow
);
    localparam logic [TAP_BITS-1:0] MID_TAP = TAP_BITS'(1) << (TAP_BITS - 1);

    // R1
    a_r1_reset_values: assert property (@(posedge clk)
        rst |=> (tap_sel == MID_TAP && !locked && !overflow));

    // R2
    a_r2_single_step: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (tap_sel == $past(tap_sel) ||
                  {1'b0, tap_sel} == {1'b0, $past(tap_sel)} + 1 ||
                  {1'b0, tap_sel} + 1 == {1'b0, $past(tap_sel)}));

    // R3
    a_r3_hold_without_decision: assert property (@(posedge clk) disable iff (rst)
        !dec_valid |=> $stable(tap_sel));

    // R4
    a_r4_lock_needs_decision: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> $past(dec_valid));

    // R7
    a_r7_fault_sticky: assert property (@(posedge clk) disable iff (rst)
        overflow |=> (overflow && !locked && $stable(tap_sel)));

    // R8
    a_r8_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(locked && overflow));

endmodule

bind dll_tap_ctrl dll_tap_ctrl_chk #(.TAP_BITS(TAP_BITS)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .dec_valid (dec_valid),
    .tap_sel   (tap_sel),
    .locked    (locked),
    .overflow  (overflow)
);

// File: tb/dll_tap_ctrl_tb.sv
module dll_tap_ctrl_tb_top;

    localparam int TB_TAP_BITS = 8;
    localparam int TB_LOCK_RUN = 8;
    localparam int TB_REFRESH  = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       dec_valid = 1'b0;
    logic       dec_early = 1'b0;
    logic [7:0] tap_sel;
    logic       locked;
    logic       overflow;

    int checks = 0;
    int errors = 0;
    int exp_tap;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    dll_tap_ctrl #(
        .TAP_BITS       (TB_TAP_BITS),
        .LOCK_RUN       (TB_LOCK_RUN),
        .REFRESH_CYCLES (TB_REFRESH)
    ) dut_i (
        .clk       (clk),
        .rst       (rst),
        .dec_valid (dec_valid),
        .dec_early (dec_early),
        .tap_sel   (tap_sel),
        .locked    (locked),
        .overflow  (overflow)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        dec_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        exp_tap = 128;
    endtask

    // One decision across one edge; sample at the following negedge.
    task automatic decide(input bit early);
        dec_valid = 1'b1;
        dec_early = early;
        @(negedge clk);
        dec_valid = 1'b0;
    endtask

    task automatic chk_state(input string req, input int et, input bit el, input bit eo);
        chk(int'(tap_sel) == et, req, int'(tap_sel), et);
        chk(locked == el, req, int'(locked), int'(el));
        chk(overflow == eo, req, int'(overflow), int'(eo));
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        do_reset();
        chk_state("R1 reset", 128, 1'b0, 1'b0);

        // R3: no decisions, no movement
        repeat (6) begin
            @(negedge clk);
            chk(int'(tap_sel) == 128, "R3 idle hold", int'(tap_sel), 128);
        end

        // R2: upward sweep to the top of the line
        for (int i = 0; i < 127; i++) begin
            decide(1'b1);
            exp_tap++;
            chk_state("R2 up sweep", exp_tap, 1'b0, 1'b0);
        end
        chk(int'(tap_sel) == 255, "R6 top reached without overflow", int'(tap_sel), 255);
        // R6: early at 255
        decide(1'b1);
        chk_state("R6 top limit", 255, 1'b0, 1'b1);
        // R7: decisions ignored after fault
        for (int i = 0; i < 6; i++) begin
            decide(i[0]);
            chk_state("R7 frozen after overflow", 255, 1'b0, 1'b1);
        end

        // R1 again after a fault
        do_reset();
        chk_state("R1 reset after fault", 128, 1'b0, 1'b0);

        // R2: downward sweep to the bottom of the line
        for (int i = 0; i < 128; i++) begin
            decide(1'b0);
            exp_tap--;
            chk_state("R2 down sweep", exp_tap, 1'b0, 1'b0);
        end
        // R6: late at 0
        decide(1'b0);
        chk_state("R6 bottom limit", 0, 1'b0, 1'b1);
        // R8 / R7
        decide(1'b1);
        chk_state("R8 R7 no lock in fault", 0, 1'b0, 1'b1);

        // R4: break the run after k alternations, then complete a full run
        for (int k = 1; k < TB_LOCK_RUN; k++) begin
            bit dir;
            do_reset();
            dir = 1'b1;
            for (int j = 0; j < k; j++) begin
                decide(dir);
                exp_tap += dir ? 1 : -1;
                chk_state("R4 partial run", exp_tap, 1'b0, 1'b0);
                dir = ~dir;
            end
            dir = ~dir;
            decide(dir);
            exp_tap += dir ? 1 : -1;
            chk_state("R4 repeat restarts run", exp_tap, 1'b0, 1'b0);
            for (int j = 1; j < TB_LOCK_RUN; j++) begin
                dir = ~dir;
                decide(dir);
                exp_tap += dir ? 1 : -1;
                chk_state("R4 run to lock", exp_tap, (j == TB_LOCK_RUN - 1), 1'b0);
            end
        end

        // R3 in TRACK: idle cycles leave the tap alone
        repeat (3) begin
            @(negedge clk);
            chk_state("R3 idle while locked", exp_tap, 1'b1, 1'b0);
        end

        // R5: fresh lock, then decisions every cycle
        do_reset();
        for (int j = 0; j < TB_LOCK_RUN; j++) begin
            decide(j[0] == 1'b0);
            exp_tap += (j[0] == 1'b0) ? 1 : -1;
        end
        chk_state("R4 locked before refresh test", exp_tap, 1'b1, 1'b0);
        dec_valid = 1'b1;
        dec_early = 1'b1;
        for (int s = 1; s <= 5 * TB_REFRESH + 1; s++) begin
            @(negedge clk);
            if (s >= TB_REFRESH + 1 && ((s - 1) % TB_REFRESH) == 0) begin
                exp_tap++;
            end
            chk_state("R5 refresh pacing", exp_tap, 1'b1, 1'b0);
        end
        dec_valid = 1'b0;

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule